// File: doc/BRIEF.md
# Per-Channel Idle Code Substitution Unit

This unit sits on the two byte-wide timeslot streams of a framed line interface, one for the transmit direction and one for the receive direction. Each stream carries a channel index with its data byte. For every byte it accepts, the unit either passes the byte through or replaces it with a stored idle code. A per-channel, per-direction enable bit makes that choice. The result leaves the unit one cycle later with its channel index.

A small register window on a microprocessor bus loads the idle codes. The codes live in one array with one byte per channel per direction. Software reaches the array indirectly: it writes a location into an address register, then reads or writes a data register. The location steps forward after each data access. Two flag bits in the address register turn a single data write into a fill of all transmit entries, all receive entries, or both. A `t1_mode` pin limits substitution to the lower channels. Framing, line coding and every other transceiver function sit outside this unit.

Top module: `idle_code_sub`

## Requirements
- R1: After reset every array entry holds 0xFF, every enable bit is 0, the address register reads 0, and both `*_out_valid` outputs are 0.
- R2: Register offsets on `cpu_addr`:
  - 0 is the address register.
  - 1 is the data register.
  - 2 to 5 are the transmit enable bytes: bit i of offset 2+k enables transmit channel index 8k+i.
  - 6 to 9 are the receive enable bytes, laid out the same way.
  - Offsets 10 to 15 read 0, and writes to them change nothing.
  - `cpu_rdata` shows the addressed register combinationally while `cpu_rd` is high.
- R3: In the address register, bits 5:0 hold the location, bit 6 is the transmit-fill flag and bit 7 is the receive-fill flag. Locations 0 to 31 hold the transmit codes for channel indices 0 to 31. Locations 32 to 63 hold the receive codes for channel indices 0 to 31.
- R4: With both fill flags clear, a data-register write stores the byte at the location. The location then increments by one, wrapping from 63 to 0.
- R5: A data-register read returns the entry at the location, whatever the fill flags say. It then increments the location (63 wraps to 0) and leaves bits 7:6 unchanged.
- R6: A data-register write with bit 6 set stores the byte into all 32 transmit entries. With bit 7 set it stores into all 32 receive entries. With both set it stores into all 64. No single-location write happens, and the address register keeps its value.
- R7: An accepted stream byte comes out on the next cycle, together with its channel index. When the channel is enabled, the output is the stored code for that direction and channel. Otherwise it is the input byte. Enables and codes are sampled in the cycle the byte is accepted.
- R8: While `t1_mode` is 1, channel indices 24 to 31 pass through unchanged, whatever their enable bits say. While it is 0, all 32 indices can be substituted.
- R9: Each stream uses a valid/ready handshake:
  - A byte transfers on a clock edge where valid and ready are both high.
  - `*_in_ready` is high when the output stage is empty or is being drained that cycle.
  - While `*_out_valid` is high and `*_out_ready` is low, the output byte and the channel index stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| t1_mode | input | 1 | 1 limits substitution to channel indices 0 to 23 |
| cpu_wr | input | 1 | Register write strobe, one cycle per access |
| cpu_rd | input | 1 | Register read strobe, one cycle per access; ignored if cpu_wr is high |
| cpu_addr | input | 4 | Register offset |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data |
| tx_in_valid | input | 1 | Transmit byte offered |
| tx_in_ready | output | 1 | Transmit byte accepted this cycle |
| tx_in_chan | input | 5 | Transmit channel index |
| tx_in_data | input | 8 | Transmit byte |
| tx_out_valid | output | 1 | Transmit result present |
| tx_out_ready | input | 1 | Downstream takes transmit result |
| tx_out_chan | output | 5 | Channel index of transmit result |
| tx_out_data | output | 8 | Transmit result byte |
| rx_in_valid | input | 1 | Receive byte offered |
| rx_in_ready | output | 1 | Receive byte accepted this cycle |
| rx_in_chan | input | 5 | Receive channel index |
| rx_in_data | input | 8 | Receive byte |
| rx_out_valid | output | 1 | Receive result present |
| rx_out_ready | input | 1 | Downstream takes receive result |
| rx_out_chan | output | 5 | Channel index of receive result |
| rx_out_data | output | 8 | Receive result byte |

## Verification
The bench builds the unit with its default parameters: 32 channels per direction, 24 of them active in T1 mode, and a 4-bit register offset. At that size a full sweep touches all 64 array locations in a pass, so one run covers the wrap from 63 to 0 and the read path with both fill flags set. It also covers every channel in both directions, in both modes, under all-on, all-off and mixed enable patterns, which brings the boundary between index 23 and 24 within reach. Every offset in the 4-bit window gets driven, including the six unused ones.

// File: rtl/idle_sub_pkg.sv
package idle_sub_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  // Register offsets whose order software relies on
  localparam int OFS_ADDR    = 0;
  localparam int OFS_DATA    = 1;
  localparam int OFS_EN_BASE = 2;

  localparam byte_t CODE_AT_RESET = 8'hFF;

  typedef enum logic [1:0] {
    ACC_NONE,
    ACC_ADDR,
    ACC_DATA,
    ACC_EN
  } acc_kind_e;
endpackage

// File: rtl/idle_code_array.sv
module idle_code_array
  import idle_sub_pkg::*;
#(
  parameter int NCH = 32,
  localparam int AW = $clog2(2 * NCH),
  localparam int CW = $clog2(NCH),
  localparam int NENT = 2 * NCH
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          fill_tx,
  input  logic          fill_rx,
  input  byte_t         wdata,
  input  logic [AW-1:0] cpu_raddr,
  output byte_t         cpu_rdata,
  input  logic [CW-1:0] tx_chan,
  output byte_t         tx_code,
  input  logic [CW-1:0] rx_chan,
  output byte_t         rx_code
);
  byte_t mem [NENT];
  logic  fill_any;

  assign fill_any = fill_tx | fill_rx;

  // Fill mode replaces the single-location write entirely.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < NENT; e++) mem[e] <= CODE_AT_RESET;
    end else if (we) begin
      for (int e = 0; e < NENT; e++) begin
        if (fill_any) begin
          if ((e < NCH) ? fill_tx : fill_rx) mem[e] <= wdata;
        end else if (waddr == AW'(e)) begin
          mem[e] <= wdata;
        end
      end
    end
  end

  assign cpu_rdata = mem[cpu_raddr];
  assign tx_code   = mem[{1'b0, tx_chan}];
  assign rx_code   = mem[{1'b1, rx_chan}];

  // A plain write lands at its location.
  assert_single_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    we && !fill_any |=> mem[$past(waddr)] == $past(wdata));

  // A transmit fill reaches both ends of the transmit half.
  assert_fill_tx_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we && fill_tx |=> mem[0] == $past(wdata) && mem[NCH-1] == $past(wdata));

  // A receive-only fill leaves the transmit half alone.
  assert_fill_rx_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we && fill_rx && !fill_tx |=> $stable(mem[0]) && mem[NENT-1] == $past(wdata));
endmodule

// File: rtl/idle_cfg_regs.sv
module idle_cfg_regs
  import idle_sub_pkg::*;
#(
  parameter int NCH = 32,
  parameter int RW  = 4,
  localparam int AW  = $clog2(2 * NCH),
  localparam int NEB = (2 * NCH) / BYTE_W,
  localparam int EW  = $clog2(NEB)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_wr,
  input  logic            cpu_rd,
  input  logic [RW-1:0]   cpu_addr,
  input  byte_t           cpu_wdata,
  output byte_t           cpu_rdata,
  output logic            mem_we,
  output logic [AW-1:0]   mem_loc,
  output logic            mem_fill_tx,
  output logic            mem_fill_rx,
  output byte_t           mem_wdata,
  input  byte_t           mem_rdata,
  output logic [NCH-1:0]  tx_en,
  output logic [NCH-1:0]  rx_en
);
  // Address register: [AW-1:0] location, [AW] tx fill, [AW+1] rx fill.
  logic [AW+1:0]      addr_q;
  logic [2*NCH-1:0]   en_q;
  acc_kind_e          kind;
  logic [EW-1:0]      en_idx;
  logic               data_wr, data_rd;
  logic [AW-1:0]      loc_next;

  always_comb begin
    kind   = ACC_NONE;
    en_idx = '0;
    if (cpu_addr == RW'(OFS_ADDR)) begin
      kind = ACC_ADDR;
    end else if (cpu_addr == RW'(OFS_DATA)) begin
      kind = ACC_DATA;
    end else begin
      for (int k = 0; k < NEB; k++) begin
        if (cpu_addr == RW'(OFS_EN_BASE + k)) begin
          kind   = ACC_EN;
          en_idx = EW'(k);
        end
      end
    end
  end

  assign data_wr  = cpu_wr && (kind == ACC_DATA);
  assign data_rd  = cpu_rd && !cpu_wr && (kind == ACC_DATA);
  assign loc_next = addr_q[AW-1:0] + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (cpu_wr && kind == ACC_ADDR) begin
      addr_q <= cpu_wdata[AW+1:0];
    end else if (data_wr) begin
      if (!(addr_q[AW] || addr_q[AW+1])) addr_q[AW-1:0] <= loc_next;
    end else if (data_rd) begin
      addr_q[AW-1:0] <= loc_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (cpu_wr && kind == ACC_EN) begin
      en_q[en_idx*BYTE_W +: BYTE_W] <= cpu_wdata;
    end
  end

  always_comb begin
    unique case (kind)
      ACC_ADDR: cpu_rdata = byte_t'(addr_q);
      ACC_DATA: cpu_rdata = mem_rdata;
      ACC_EN:   cpu_rdata = en_q[en_idx*BYTE_W +: BYTE_W];
      default:  cpu_rdata = '0;
    endcase
  end

  assign mem_we      = data_wr;
  assign mem_loc     = addr_q[AW-1:0];
  assign mem_fill_tx = addr_q[AW];
  assign mem_fill_rx = addr_q[AW+1];
  assign mem_wdata   = cpu_wdata;
  assign tx_en       = en_q[NCH-1:0];
  assign rx_en       = en_q[2*NCH-1:NCH];

  // Location wraps from the last entry to zero.
  assert_loc_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && !(addr_q[AW] || addr_q[AW+1]) && addr_q[AW-1:0] == '1
    |=> addr_q[AW-1:0] == '0);

  // A fill write leaves the address register as it was.
  assert_fill_keeps_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr && (addr_q[AW] || addr_q[AW+1]) |=> $stable(addr_q));

  // A data read keeps the fill flags.
  assert_read_keeps_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |=> addr_q[AW+1:AW] == $past(addr_q[AW+1:AW]));
endmodule

// File: rtl/idle_sub_path.sv
module idle_sub_path
  import idle_sub_pkg::*;
#(
  parameter int NCH         = 32,
  parameter int T1_CHANNELS = 24,
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           t1_mode,
  input  logic [NCH-1:0] en,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [CW-1:0]  in_chan,
  input  byte_t          in_data,
  output logic [CW-1:0]  code_chan,
  input  byte_t          code,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [CW-1:0]  out_chan,
  output byte_t          out_data
);
  logic take, in_window, subst;

  assign in_ready  = !out_valid || out_ready;
  assign take      = in_valid && in_ready;
  assign code_chan = in_chan;
  assign in_window = !t1_mode || (32'(in_chan) < T1_CHANNELS);
  assign subst     = en[in_chan] && in_window;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chan <= in_chan;
        out_data <= subst ? code : in_data;
      end
    end
  end

  // Stalled output holds still.
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_chan));

  // Every accepted byte shows up on the next cycle.
  assert_accept_emits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid && out_chan == $past(in_chan));

  // Disabled channels pass through.
  assert_disabled_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take && !en[in_chan] |=> out_data == $past(in_data));

  // Upper channels pass through in T1 mode.
  assert_t1_upper_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take && t1_mode && 32'(in_chan) >= T1_CHANNELS |=> out_data == $past(in_data));
endmodule

// File: rtl/idle_code_sub.sv
module idle_code_sub
  import idle_sub_pkg::*;
#(
  parameter int NCH         = 32,
  parameter int T1_CHANNELS = 24,
  parameter int RW          = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   t1_mode,
  input  logic                   cpu_wr,
  input  logic                   cpu_rd,
  input  logic [RW-1:0]          cpu_addr,
  input  logic [7:0]             cpu_wdata,
  output logic [7:0]             cpu_rdata,
  input  logic                   tx_in_valid,
  output logic                   tx_in_ready,
  input  logic [$clog2(NCH)-1:0] tx_in_chan,
  input  logic [7:0]             tx_in_data,
  output logic                   tx_out_valid,
  input  logic                   tx_out_ready,
  output logic [$clog2(NCH)-1:0] tx_out_chan,
  output logic [7:0]             tx_out_data,
  input  logic                   rx_in_valid,
  output logic                   rx_in_ready,
  input  logic [$clog2(NCH)-1:0] rx_in_chan,
  input  logic [7:0]             rx_in_data,
  output logic                   rx_out_valid,
  input  logic                   rx_out_ready,
  output logic [$clog2(NCH)-1:0] rx_out_chan,
  output logic [7:0]             rx_out_data
);
  localparam int AW = $clog2(2 * NCH);
  localparam int CW = $clog2(NCH);

  logic          mem_we, fill_tx, fill_rx;
  logic [AW-1:0] mem_loc;
  byte_t         mem_wdata, mem_rdata, tx_code, rx_code;
  logic [NCH-1:0] tx_en, rx_en;
  logic [CW-1:0] tx_lookup, rx_lookup;

  idle_cfg_regs #(.NCH(NCH), .RW(RW)) u_cfg (
    .clk, .rst_n, .cpu_wr, .cpu_rd, .cpu_addr, .cpu_wdata, .cpu_rdata,
    .mem_we, .mem_loc, .mem_fill_tx(fill_tx), .mem_fill_rx(fill_rx),
    .mem_wdata, .mem_rdata, .tx_en, .rx_en
  );

  idle_code_array #(.NCH(NCH)) u_array (
    .clk, .rst_n, .we(mem_we), .waddr(mem_loc), .fill_tx, .fill_rx,
    .wdata(mem_wdata), .cpu_raddr(mem_loc), .cpu_rdata(mem_rdata),
    .tx_chan(tx_lookup), .tx_code, .rx_chan(rx_lookup), .rx_code
  );

  idle_sub_path #(.NCH(NCH), .T1_CHANNELS(T1_CHANNELS)) u_tx (
    .clk, .rst_n, .t1_mode, .en(tx_en),
    .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_chan(tx_in_chan),
    .in_data(tx_in_data), .code_chan(tx_lookup), .code(tx_code),
    .out_valid(tx_out_valid), .out_ready(tx_out_ready),
    .out_chan(tx_out_chan), .out_data(tx_out_data)
  );

  idle_sub_path #(.NCH(NCH), .T1_CHANNELS(T1_CHANNELS)) u_rx (
    .clk, .rst_n, .t1_mode, .en(rx_en),
    .in_valid(rx_in_valid), .in_ready(rx_in_ready), .in_chan(rx_in_chan),
    .in_data(rx_in_data), .code_chan(rx_lookup), .code(rx_code),
    .out_valid(rx_out_valid), .out_ready(rx_out_ready),
    .out_chan(rx_out_chan), .out_data(rx_out_data)
  );
endmodule

// File: tb/idle_code_sub_test.sv
module idle_code_sub_test;
  logic clk = 0, rst_n = 0, t1_mode = 0;
  logic cpu_wr = 0, cpu_rd = 0;
  logic [3:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata;
  logic tx_in_valid = 0, tx_in_ready, tx_out_valid, tx_out_ready = 1;
  logic rx_in_valid = 0, rx_in_ready, rx_out_valid, rx_out_ready = 1;
  logic [4:0] tx_in_chan = 0, tx_out_chan, rx_in_chan = 0, rx_out_chan;
  logic [7:0] tx_in_data = 0, tx_out_data, rx_in_data = 0, rx_out_data;

  int nchk = 0, nerr = 0;
  int mem_m [64];
  bit en_m [2][32];
  bit done = 0;

  always #4 clk = ~clk;

  idle_code_sub uut (.*);

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(int off, int d);
    @(negedge clk); cpu_wr = 1; cpu_addr = 4'(off); cpu_wdata = 8'(d);
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic reg_rd(int off, output int d);
    @(negedge clk); cpu_rd = 1; cpu_addr = 4'(off);
    #1 d = cpu_rdata;
    @(negedge clk); cpu_rd = 0;
  endtask

  task automatic set_en(int dir, int pat);
    for (int k = 0; k < 4; k++) begin
      reg_wr(2 + 4*dir + k, pat);
      for (int i = 0; i < 8; i++) en_m[dir][8*k+i] = pat[i];
    end
  endtask

  function automatic int expect_out(int dir, int ch, int d);
    if (en_m[dir][ch] && !(t1_mode && ch >= 24)) return mem_m[32*dir + ch];
    return d;
  endfunction

  task automatic xfer(int dir, int ch, int d, output int got, output int gch);
    @(negedge clk);
    if (dir == 1) begin rx_in_valid = 1; rx_in_chan = 5'(ch); rx_in_data = 8'(d); end
    else begin tx_in_valid = 1; tx_in_chan = 5'(ch); tx_in_data = 8'(d); end
    @(negedge clk);
    tx_in_valid = 0; rx_in_valid = 0;
    if (dir == 1) begin got = rx_out_valid ? int'(rx_out_data) : -1; gch = rx_out_chan; end
    else begin got = tx_out_valid ? int'(tx_out_data) : -1; gch = tx_out_chan; end
  endtask

  task automatic sweep(string req);
    int got, gch;
    for (int dir = 0; dir < 2; dir++)
      for (int ch = 0; ch < 32; ch++) begin
        xfer(dir, ch, (ch * 13 + dir * 7 + 1) & 8'hFF, got, gch);
        chk(req, got, expect_out(dir, ch, (ch * 13 + dir * 7 + 1) & 8'hFF));
        chk(req, gch, ch);
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    int v;
    int pats [3] = '{8'hFF, 8'h00, 8'hA5};
    for (int i = 0; i < 64; i++) mem_m[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    chk("R1 tx_out_valid", tx_out_valid, 0);
    chk("R1 rx_out_valid", rx_out_valid, 0);
    reg_rd(0, v); chk("R1 addr reg", v, 0);
    for (int k = 2; k < 10; k++) begin reg_rd(k, v); chk("R1 enable reg", v, 0); end
    for (int i = 0; i < 64; i++) begin reg_rd(1, v); chk("R1 array reset", v, 8'hFF); end
    reg_rd(0, v); chk("R5 read wrap", v, 0);

    // R4: auto-increment writes over all 64 locations, with wrap
    for (int i = 0; i < 64; i++) begin
      mem_m[i] = (i * 37 + 5) & 8'hFF;
      reg_wr(1, mem_m[i]);
    end
    reg_rd(0, v); chk("R4 write wrap", v, 0);

    // R5: reads ignore fill flags and keep them
    reg_wr(0, 8'hC0);
    for (int i = 0; i < 64; i++) begin reg_rd(1, v); chk("R5 readback", v, mem_m[i]); end
    reg_rd(0, v); chk("R5 flags kept", v, 8'hC0);
    reg_wr(0, 8'h3F); reg_rd(1, v); chk("R3 last location", v, mem_m[63]);

    // R2: enable bytes read back; unused offsets inert
    set_en(0, 8'h5C); set_en(1, 8'h3A);
    reg_rd(3, v); chk("R2 tx enable", v, 8'h5C);
    reg_rd(9, v); chk("R2 rx enable", v, 8'h3A);
    reg_wr(0, 8'h05);
    for (int k = 10; k < 16; k++) reg_wr(k, 8'hFF);
    for (int k = 10; k < 16; k++) begin reg_rd(k, v); chk("R2 unused reads 0", v, 0); end
    reg_rd(0, v); chk("R2 addr untouched", v, 8'h05);
    reg_rd(5, v); chk("R2 tx enable untouched", v, 8'h5C);
    reg_rd(6, v); chk("R2 rx enable untouched", v, 8'h3A);
    reg_rd(1, v); chk("R2 array untouched", v, mem_m[5]);

    // R3 R7 R8: sweep every channel, both directions, modes and patterns
    for (int m = 0; m < 2; m++) begin
      @(negedge clk); t1_mode = m[0];
      foreach (pats[p]) begin
        set_en(0, pats[p]); set_en(1, pats[(p + 1) % 3]);
        sweep(m ? "R8 t1 sweep" : "R7 e1 sweep");
      end
    end
    @(negedge clk); t1_mode = 0;

    // R6: fills, address register unchanged
    reg_wr(0, 8'h45); reg_wr(1, 8'h3C);
    for (int i = 0; i < 32; i++) mem_m[i] = 8'h3C;
    reg_rd(0, v); chk("R6 tx fill keeps addr", v, 8'h45);
    reg_wr(0, 8'h80 | 8'd9); reg_wr(1, 8'h77);
    for (int i = 32; i < 64; i++) mem_m[i] = 8'h77;
    reg_rd(0, v); chk("R6 rx fill keeps addr", v, 8'h89);
    reg_wr(0, 0);
    for (int i = 0; i < 64; i++) begin reg_rd(1, v); chk("R6 half fills", v, mem_m[i]); end
    reg_wr(0, 8'hC0 | 8'd63); reg_wr(1, 8'h11);
    for (int i = 0; i < 64; i++) mem_m[i] = 8'h11;
    reg_rd(0, v); chk("R6 full fill keeps addr", v, 8'hFF);
    reg_wr(0, 0);
    for (int i = 0; i < 64; i++) begin reg_rd(1, v); chk("R6 full fill", v, 8'h11); end

    // R9: back-pressure on transmit
    set_en(0, 8'h00);
    @(negedge clk); tx_out_ready = 0; tx_in_valid = 1; tx_in_chan = 3; tx_in_data = 8'h21;
    @(negedge clk);
    chk("R9 out valid", tx_out_valid, 1);
    chk("R9 first data", tx_out_data, 8'h21);
    tx_in_chan = 4; tx_in_data = 8'h22;
    chk("R9 in_ready low when full", tx_in_ready, 0);
    repeat (3) begin
      @(negedge clk);
      chk("R9 held data", tx_out_data, 8'h21);
      chk("R9 held chan", tx_out_chan, 3);
    end
    chk("R9 in_ready drains", tx_in_ready, 0);
    tx_out_ready = 1;
    #1 chk("R9 in_ready when draining", tx_in_ready, 1);
    @(negedge clk);
    tx_in_valid = 0;
    chk("R9 second data", tx_out_data, 8'h22);
    chk("R9 second chan", tx_out_chan, 4);
    @(negedge clk);
    chk("R9 empty after drain", tx_out_valid, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule